// File: doc/BRIEF.md
# Host-Side Parallel Printer Port Controller

This block sits between a host register bus and a parallel printer connector. Software sees four byte-wide registers: a data byte, a read-only snapshot of the printer status pins, a control byte that drives the printer control pins and sets the bus direction, and an address register used by the enhanced mode. In standard mode software bit-bangs the strobe through the control register. In enhanced mode, a host access to the address register starts a hardware address handshake on the connector. A timer bounds that handshake.

An address write drives the byte onto the port bus and pulls the address strobe and the write strobe low. It then waits until the peripheral raises its wait line (the busy pin), and releases both strobes. An address read floats the bus and pulls only the address strobe low. On the same wait condition it captures the bus byte and returns it to the host. If the wait line does not rise within the timeout window, the cycle is aborted, the strobes are released and a sticky timeout flag is set. The timeout window is `CLK_HZ/1000*TIMEOUT_MS` clock cycles. While a cycle runs, `hostBusy` is high and other host accesses are ignored.

All printer-side inputs pass through a synchronizer before use. When interrupts are enabled, a falling edge on the acknowledge pin produces a one-cycle interrupt pulse.

Top module: `parport_port`

## Requirements
- R1: After reset the control register reads 0xC0, `strobeN`, `autoFdN` and `selInN` are 1, `initN` is 0, `pdOe` is 1, `pdOut` is 0x00, and `irq` and `hostBusy` are 0.
- R2: The register addresses are 0 for data, 1 for status, 2 for control and 3 for the enhanced-mode address. Control bits 3, 1 and 0 drive `selInN`, `autoFdN` and `strobeN` inverted. Control bit 2 drives `initN` directly. Control bits 7 and 6 always read as 1.
- R3: With control bit 5 at 0, `pdOe` is 1, `pdOut` carries the data register, and a data read returns the data register. With bit 5 at 1, `pdOe` is 0 and a data read returns the synchronized `pdIn`.
- R4: A status read returns {~busyIn, ackN, paperEnd, selectIn, errN, 1, 1, t}. The pins are taken after the synchronizer. A register read returns `rdData` with `rdValid` high on the clock after `regRd`.
- R5: When `eppMode` is 0, status bit 0 (t) reads 1. When `eppMode` is 1, t equals the timeout flag.
- R6: In enhanced mode, a write to address 3 raises `hostBusy`, drives the written byte on `pdOut` with `pdOe` at 1, and pulls `selInN` and `strobeN` low. After the synchronized `busyIn` reads 1, the cycle releases both strobes and drops `hostBusy`.
- R7: In enhanced mode, a read of address 3 sets `pdOe` to 0, pulls `selInN` low and keeps `strobeN` high. When the synchronized `busyIn` reads 1, it returns the synchronized `pdIn` byte with `rdValid`.
- R8: If `busyIn` stays low for the timeout window, the cycle ends about `CLK_HZ/1000*TIMEOUT_MS` cycles after it starts. The strobes are released, the timeout flag is set, and an aborted read returns 0xFF.
- R9: The timeout flag clears when the host writes status with bit 0 at 1, and when `eppMode` changes.
- R10: With `eppMode` at 0, a write to address 3 starts no cycle and leaves the pins unchanged. A read of address 3 returns 0xFF.
- R11: With control bit 4 at 1, a falling edge on `ackN` gives a one-cycle `irq` pulse. With bit 4 at 0, no pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| eppMode | input | 1 | 1 selects enhanced mode |
| regAddr | input | 2 | Host register select |
| regWr | input | 1 | Host write strobe, one cycle |
| regRd | input | 1 | Host read strobe, one cycle |
| wrData | input | 8 | Host write byte |
| rdData | output | 8 | Host read byte |
| rdValid | output | 1 | rdData valid, one cycle |
| hostBusy | output | 1 | Enhanced address cycle in progress |
| pdOut | output | 8 | Port data bus, outgoing value |
| pdOe | output | 1 | Port data bus output enable |
| pdIn | input | 8 | Port data bus, pin values |
| strobeN | output | 1 | Data strobe / write strobe pin |
| autoFdN | output | 1 | Auto line feed pin |
| initN | output | 1 | Printer initialize pin |
| selInN | output | 1 | Select-in / address strobe pin |
| busyIn | input | 1 | Printer busy / wait pin |
| ackN | input | 1 | Printer acknowledge pin |
| paperEnd | input | 1 | Paper end pin |
| selectIn | input | 1 | Printer selected pin |
| errN | input | 1 | Printer error pin |
| irq | output | 1 | Interrupt request pulse |

## Verification
The status register is read under two complementary pin patterns, so that each bit is set once and cleared once. This separates a wrong bit position from a missing inversion. Control writes with only the inverted bits set and with only the initialize bit set show the polarity of each pin on its own.

Enhanced address cycles are run three ways: as a write whose wait line answers, as a read whose wait line answers, and as a write whose wait line never answers. These show strobe selection, bus direction and the abort path. The timeout flag is cleared once through a status write and once through a mode change. An address access in standard mode shows that no cycle starts.

// File: rtl/parport_pkg.sv
package parport_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    REG_DATA  = 2'd0,
    REG_STAT  = 2'd1,
    REG_CTRL  = 2'd2,
    REG_EADDR = 2'd3
  } regSel_e;

  typedef struct packed {
    logic addrStrobe;
    logic writeStrobe;
    logic driveAddr;
    logic floatBus;
    logic loadAddr;
    logic readDone;
    logic timeoutHit;
    logic cycleBusy;
  } eppCtl_t;
endpackage

// File: rtl/parport_sync.sv
module parport_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] dOut
);
  logic [W-1:0] pipe [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) pipe[0] <= '0;
          else       pipe[0] <= dIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) pipe[s] <= '0;
          else       pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign dOut = pipe[STAGES-1];
endmodule

// File: rtl/parport_epp_ctrl.sv
module parport_epp_ctrl
  import parport_pkg::*;
#(
  parameter int TMO_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       eppMode,
  input  logic [1:0] regAddr,
  input  logic       regWr,
  input  logic       regRd,
  input  logic       waitSeen,
  output eppCtl_t    ctl
);
  localparam int CW = $clog2(TMO_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ACTIVE, ST_FINISH} eppState_e;

  eppState_e state;
  logic [CW-1:0] cnt;
  logic isRead;
  logic startReq;
  logic hitTmo;

  assign startReq = (state == ST_IDLE) && eppMode &&
                    (regAddr == REG_EADDR) && (regWr || regRd);
  assign hitTmo   = (state == ST_ACTIVE) && !waitSeen && (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      isRead <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (startReq) begin
          state  <= ST_ACTIVE;
          cnt    <= '0;
          isRead <= !regWr;
        end
        ST_ACTIVE: begin
          if (waitSeen || cnt == LAST) state <= ST_FINISH;
          else                         cnt   <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.cycleBusy   = (state != ST_IDLE);
    ctl.loadAddr    = startReq && regWr;
    ctl.addrStrobe  = (state == ST_ACTIVE);
    ctl.writeStrobe = (state == ST_ACTIVE) && !isRead;
    ctl.driveAddr   = (state != ST_IDLE) && !isRead;
    ctl.floatBus    = (state != ST_IDLE) && isRead;
    ctl.timeoutHit  = hitTmo;
    ctl.readDone    = (state == ST_ACTIVE) && isRead && (waitSeen || hitTmo);
  end

  // R8: the wait counter never runs past the timeout window
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    cnt < CW'(TMO_CYCLES));

  // R10: no enhanced cycle starts while in standard mode
  p_no_cycle_spp_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !eppMode) |=> (state == ST_IDLE));

  // R6: a cycle always passes through the release state back to idle
  p_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FINISH) |=> (state == ST_IDLE));
endmodule

// File: rtl/parport_datapath.sv
module parport_datapath
  import parport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eppMode,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output logic              rdValid,
  input  eppCtl_t           ctl,
  output logic              waitSeen,
  output logic [BYTE_W-1:0] pdOut,
  output logic              pdOe,
  input  logic [BYTE_W-1:0] pdIn,
  output logic              strobeN,
  output logic              autoFdN,
  output logic              initN,
  output logic              selInN,
  input  logic              busyIn,
  input  logic              ackN,
  input  logic              paperEnd,
  input  logic              selectIn,
  input  logic              errN,
  output logic              irq
);
  localparam int PIN_W = BYTE_W + 5;

  logic [PIN_W-1:0] pinsRaw, pinsSync;
  logic [BYTE_W-1:0] pdSync;
  logic busyS, ackS, peS, selS, errS;

  assign pinsRaw = {pdIn, busyIn, ackN, paperEnd, selectIn, errN};

  parport_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rstN(rstN), .dIn(pinsRaw), .dOut(pinsSync)
  );

  assign {pdSync, busyS, ackS, peS, selS, errS} = pinsSync;
  assign waitSeen = busyS;

  logic [BYTE_W-1:0] dataReg, addrByte;
  logic dirIn, irqEn, slinBit, initBit, afdBit, stbBit;
  logic tmoFlag, prevMode, modeChg, ackPrev;
  logic hostOk;
  logic [BYTE_W-1:0] statusByte, ctrlByte, regMux;

  assign modeChg    = (eppMode != prevMode);
  assign hostOk     = !ctl.cycleBusy;
  assign statusByte = {~busyS, ackS, peS, selS, errS, 2'b11,
                       (eppMode ? tmoFlag : 1'b1)};
  assign ctrlByte   = {2'b11, dirIn, irqEn, slinBit, initBit, afdBit, stbBit};

  always_comb begin
    case (regAddr)
      REG_DATA: regMux = dirIn ? pdSync : dataReg;
      REG_STAT: regMux = statusByte;
      REG_CTRL: regMux = ctrlByte;
      default:  regMux = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg  <= '0;
      addrByte <= '0;
      {dirIn, irqEn, slinBit, initBit, afdBit, stbBit} <= '0;
    end else begin
      if (ctl.loadAddr) addrByte <= wrData;
      if (regWr && hostOk) begin
        if (regAddr == REG_DATA) dataReg <= wrData;
        if (regAddr == REG_CTRL)
          {dirIn, irqEn, slinBit, initBit, afdBit, stbBit} <= wrData[5:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmoFlag  <= 1'b0;
      prevMode <= 1'b0;
    end else begin
      prevMode <= eppMode;
      if (modeChg)                tmoFlag <= 1'b0;
      else if (ctl.timeoutHit)    tmoFlag <= 1'b1;
      else if (regWr && hostOk && regAddr == REG_STAT && wrData[0])
                                  tmoFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= 1'b0;
      if (ctl.readDone) begin
        rdValid <= 1'b1;
        rdData  <= ctl.timeoutHit ? 8'hFF : pdSync;
      end else if (regRd && hostOk && !(eppMode && regAddr == REG_EADDR)) begin
        rdValid <= 1'b1;
        rdData  <= regMux;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackPrev <= 1'b0;
      irq     <= 1'b0;
    end else begin
      ackPrev <= ackS;
      irq     <= irqEn && ackPrev && !ackS;
    end
  end

  assign pdOut   = ctl.driveAddr ? addrByte : dataReg;
  assign pdOe    = ctl.driveAddr || (!ctl.floatBus && !dirIn);
  assign strobeN = ~(stbBit | ctl.writeStrobe);
  assign selInN  = ~(slinBit | ctl.addrStrobe);
  assign autoFdN = ~afdBit;
  assign initN   = initBit;

  // R3: input direction with no address write running leaves the bus undriven
  p_dir_float_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dirIn && !ctl.driveAddr) |-> !pdOe);

  // R9: a mode change leaves the timeout flag clear
  p_mode_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    modeChg |=> !tmoFlag);

  // R11: an interrupt pulse needs the enable bit on the cycle before
  p_irq_en_r11: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(irqEn));

  // R11: the interrupt is a single-cycle pulse
  p_irq_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R7: a read cycle never drives the bus
  p_read_float_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.floatBus |-> !pdOe);
endmodule

// File: rtl/parport_port.sv
module parport_port
  import parport_pkg::*;
#(
  parameter int CLK_HZ      = 250_000_000,
  parameter int TIMEOUT_MS  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       eppMode,
  input  logic [1:0] regAddr,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       rdValid,
  output logic       hostBusy,
  output logic [7:0] pdOut,
  output logic       pdOe,
  input  logic [7:0] pdIn,
  output logic       strobeN,
  output logic       autoFdN,
  output logic       initN,
  output logic       selInN,
  input  logic       busyIn,
  input  logic       ackN,
  input  logic       paperEnd,
  input  logic       selectIn,
  input  logic       errN,
  output logic       irq
);
  localparam int TMO_CYCLES = (CLK_HZ / 1000) * TIMEOUT_MS;

  eppCtl_t ctl;
  logic waitSeen;

  parport_epp_ctrl #(.TMO_CYCLES(TMO_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .eppMode(eppMode), .regAddr(regAddr),
    .regWr(regWr), .regRd(regRd), .waitSeen(waitSeen), .ctl(ctl)
  );

  parport_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .eppMode(eppMode), .regAddr(regAddr),
    .regWr(regWr), .regRd(regRd), .wrData(wrData), .rdData(rdData),
    .rdValid(rdValid), .ctl(ctl), .waitSeen(waitSeen), .pdOut(pdOut),
    .pdOe(pdOe), .pdIn(pdIn), .strobeN(strobeN), .autoFdN(autoFdN),
    .initN(initN), .selInN(selInN), .busyIn(busyIn), .ackN(ackN),
    .paperEnd(paperEnd), .selectIn(selectIn), .errN(errN), .irq(irq)
  );

  assign hostBusy = ctl.cycleBusy;
endmodule

// File: tb/parport_port_bench.sv
module parport_port_bench;
  localparam int TMO = 1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eppMode = 1'b0;
  logic [1:0] regAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData, pdOut;
  logic rdValid, hostBusy, pdOe, strobeN, autoFdN, initN, selInN, irq;
  logic [7:0] pdIn = '0;
  logic busyIn = 1'b0, ackN = 1'b1, paperEnd = 1'b0, selectIn = 1'b0, errN = 1'b1;

  int nRun = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  parport_port #(.CLK_HZ(100_000), .TIMEOUT_MS(10), .SYNC_STAGES(2)) u_parport_port (
    .clk(clk), .rstN(rstN), .eppMode(eppMode), .regAddr(regAddr),
    .regWr(regWr), .regRd(regRd), .wrData(wrData), .rdData(rdData),
    .rdValid(rdValid), .hostBusy(hostBusy), .pdOut(pdOut), .pdOe(pdOe),
    .pdIn(pdIn), .strobeN(strobeN), .autoFdN(autoFdN), .initN(initN),
    .selInN(selInN), .busyIn(busyIn), .ackN(ackN), .paperEnd(paperEnd),
    .selectIn(selectIn), .errN(errN), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
    d = 8'hxx;
    for (int i = 0; i < 2000; i++) begin
      if (rdValid) begin d = rdData; break; end
      @(negedge clk);
    end
  endtask

  task automatic waitIdle(output int cycles);
    cycles = 0;
    while (hostBusy && cycles < 3000) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 strobeN", strobeN, 1);
    check("R1 autoFdN", autoFdN, 1);
    check("R1 selInN", selInN, 1);
    check("R1 initN", initN, 0);
    check("R1 pdOe", pdOe, 1);
    check("R1 pdOut", pdOut, 0);
    check("R1 irq/busy", {irq, hostBusy}, 0);
    rd(2'd2, v);
    check("R1 ctrl read", v, 8'hC0);
  endtask

  task automatic t_control;
    logic [7:0] v;
    wr(2'd2, 8'h0B);
    check("R2 pins inv", {selInN, autoFdN, strobeN, initN}, 4'b0000);
    rd(2'd2, v);
    check("R2 ctrl readback", v, 8'hCB);
    wr(2'd2, 8'h04);
    check("R2 init direct", {selInN, autoFdN, strobeN, initN}, 4'b1111);
    rd(2'd2, v);
    check("R2 ctrl readback init", v, 8'hC4);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_direction;
    logic [7:0] v;
    wr(2'd0, 8'hA5);
    check("R3 drive out", {pdOe, pdOut}, {1'b1, 8'hA5});
    rd(2'd0, v);
    check("R3 data latch read", v, 8'hA5);
    pdIn = 8'h3C;
    wr(2'd2, 8'h20);
    check("R3 float", pdOe, 0);
    idle(3);
    rd(2'd0, v);
    check("R3 pin read", v, 8'h3C);
    wr(2'd2, 8'h00);
    check("R3 drive restored", pdOe, 1);
  endtask

  task automatic t_status;
    logic [7:0] v;
    busyIn = 0; ackN = 1; paperEnd = 1; selectIn = 0; errN = 0;
    idle(4);
    rd(2'd1, v);
    check("R4 status pattern A (R5 bit0 in SPP)", v, 8'hE7);
    busyIn = 1; ackN = 0; paperEnd = 0; selectIn = 1; errN = 1;
    idle(4);
    rd(2'd1, v);
    check("R4 status pattern B", v, 8'h1F);
    busyIn = 0; ackN = 1; errN = 1; selectIn = 0;
    idle(4);
  endtask

  task automatic t_spp_addr;
    logic [7:0] v;
    wr(2'd0, 8'h11);
    wr(2'd3, 8'h77);
    check("R10 no cycle", {hostBusy, selInN, strobeN, pdOut}, {1'b0, 1'b1, 1'b1, 8'h11});
    rd(2'd3, v);
    check("R10 addr read spp", v, 8'hFF);
  endtask

  task automatic t_epp_write;
    logic [7:0] v;
    int n;
    eppMode = 1; idle(3);
    wr(2'd3, 8'hC3);
    check("R6 strobes low", {hostBusy, selInN, strobeN}, 3'b100);
    check("R6 address on bus", {pdOe, pdOut}, {1'b1, 8'hC3});
    idle(5);
    check("R6 still waiting", {hostBusy, selInN}, 2'b10);
    busyIn = 1;
    waitIdle(n);
    check("R6 completes", n < 10, 1);
    check("R6 strobes released", {selInN, strobeN}, 2'b11);
    rd(2'd1, v);
    check("R6 no timeout flag", v[0], 0);
    busyIn = 0; idle(4);
  endtask

  task automatic t_epp_read;
    logic [7:0] v;
    pdIn = 8'h5A;
    @(negedge clk);
    regAddr = 2'd3; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
    check("R7 read strobes", {hostBusy, pdOe, selInN, strobeN}, 4'b1001);
    idle(3);
    busyIn = 1;
    v = 8'hxx;
    for (int i = 0; i < 20; i++) begin
      if (rdValid) begin v = rdData; break; end
      @(negedge clk);
    end
    check("R7 read byte", v, 8'h5A);
    busyIn = 0; idle(4);
  endtask

  task automatic t_timeout;
    logic [7:0] v;
    int n;
    wr(2'd3, 8'h42);
    waitIdle(n);
    check("R8 window length", (n >= TMO - 5 && n <= TMO + 5), 1);
    check("R8 strobes released", {selInN, strobeN}, 2'b11);
    rd(2'd1, v);
    check("R8 flag set", v[0], 1);
    wr(2'd1, 8'h01);
    rd(2'd1, v);
    check("R9 write-one clear", v[0], 0);
    @(negedge clk);
    regAddr = 2'd3; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
    v = 8'h00;
    for (int i = 0; i < TMO + 20; i++) begin
      if (rdValid) begin v = rdData; break; end
      @(negedge clk);
    end
    check("R8 aborted read value", v, 8'hFF);
    rd(2'd1, v);
    check("R8 flag set by read abort", v[0], 1);
    eppMode = 0; idle(2);
    eppMode = 1; idle(2);
    rd(2'd1, v);
    check("R9 mode change clear", v[0], 0);
  endtask

  task automatic t_irq;
    int seen;
    wr(2'd2, 8'h10);
    ackN = 0;
    seen = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); seen += irq; end
    check("R11 irq pulse enabled", seen, 1);
    ackN = 1; idle(4);
    wr(2'd2, 8'h00);
    ackN = 0;
    seen = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); seen += irq; end
    check("R11 irq disabled", seen, 0);
    ackN = 1; idle(4);
  endtask

  initial begin
    #(4 * 150000);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    t_reset();
    t_control();
    t_direction();
    t_status();
    t_spp_addr();
    t_epp_write();
    t_epp_read();
    t_timeout();
    t_irq();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule